// File: doc/BRIEF.md
# CORDIC Butterfly Processing Element (radix-2² / dual radix-2)

This block performs one decimation-in-frequency butterfly on four complex samples and then applies the twiddle rotations with a single shared iterative CORDIC rotator. Because the rotator takes the twiddles as angles, no coefficient table is needed. A one-bit mode input selects the operation. With the mode low, the block computes one four-point radix-2² butterfly, and the multiply by −j inside it is folded into the add/subtract network. With the mode high, it computes two independent two-point butterflies at the same time.

A controller pulses `start` while the block is idle. The inputs are captured and the add/subtract stage is registered on that same edge. The three rotated outputs are then processed one after another. A rotation with a zero residual angle skips the CORDIC iterations and costs only two cycles. The CORDIC gain is removed by one constant multiply at the end of each full rotation. `done` pulses once when all three rotations are finished, and the results stay unchanged until the next accepted start.

Top module: `cbf_pe`

## Requirements
- R1: Each complex port packs the real part in bits [23:12] and the imaginary part in bits [11:0], both 12-bit two's complement. With `pair_mode`=0, let a=x0+x2, b=x0−x2, c=x1+x3 and d=x1−x3. Before rotation the outputs are y0=a+c, y1=a−c, y2=b−j·d = (b.re+d.im, b.im−d.re) and y3=b+j·d = (b.re−d.im, b.im+d.re).
- R2: With `pair_mode`=1, the outputs before rotation are y0=x0+x1, y1=x0−x1, y2=x2+x3 and y3=x2−x3.
- R3: Every addition and subtraction in the butterfly stage saturates to the range [−2048, 2047] instead of wrapping.
- R4: y0 is never rotated. Each yk (k=1..3) is rotated counterclockwise by angk·π/2048, where angk is 12-bit two's complement. The result saturates to 12 bits and lies within 4 LSB of the exact rotation.
- R5: An angle of 0 leaves its output bit-exact. An angle of −2048 (π) gives the exact negation, saturated, so −2048 becomes 2047. Both cases take 2 cycles instead of 15.
- R6: `done` rises exactly L clock edges after the accepted start edge. L is the sum over k=1..3 of 2 when angk is 0 or −2048, and 15 otherwise, so L is at least 6.
- R7: `busy` is high from the start edge until the edge that raises `done`. `done` is a one-cycle pulse during which `busy` is low. A `start` while `busy` is high is ignored.
- R8: After reset, `busy` and `done` are low and all outputs are zero.
- R9: Outputs do not change from the `done` pulse until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a butterfly; honoured only while idle |
| pair_mode | input | 1 | 0: one radix-2² butterfly, 1: two radix-2 butterflies |
| x0 | input | 24 | Complex input 0 {re, im} |
| x1 | input | 24 | Complex input 1 |
| x2 | input | 24 | Complex input 2 |
| x3 | input | 24 | Complex input 3 |
| ang1 | input | 12 | Rotation angle for y1, units of π/2048 |
| ang2 | input | 12 | Rotation angle for y2 |
| ang3 | input | 12 | Rotation angle for y3 |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| y0 | output | 24 | Complex output 0 (never rotated) |
| y1 | output | 24 | Complex output 1 |
| y2 | output | 24 | Complex output 2 |
| y3 | output | 24 | Complex output 3 |

## Verification
The same four input samples are run through both modes with all angles zero. Because each output is then bit-exact, this separates the radix-2² pairing and the ±j placement from the two-pair pairing. Near-full-scale inputs show saturation as opposed to wrap-around. Angles across all four quadrants, including ±π/2 and angles beyond ±π/2, exercise the half-turn fold and the iterative rotation against a floating-point model. Mixed sets of zero, π and general angles show the early-finish path, both in its bit-exact values and in the cycle on which `done` appears. A start issued mid-operation shows that it is ignored.

// File: rtl/cbf_pkg.sv
package cbf_pkg;

    localparam int CW = 12;            // component width
    localparam int AW = 12;            // angle width, units of pi/2^(AW-1)
    localparam int ZX = 4;             // extra fraction bits of the angle accumulator
    localparam int ZW = AW + ZX + 1;   // angle accumulator width

    typedef logic signed [CW-1:0] comp_t;

    typedef struct packed {
        comp_t re;
        comp_t im;
    } cplx_t;

    typedef enum logic [1:0] {R_IDLE, R_ITER, R_COMP} rot_state_t;
    typedef enum logic {S_IDLE, S_ROT} seq_state_t;

    // saturating add (sub=0) or subtract (sub=1) of two components
    function automatic comp_t sat_sum(input comp_t a, input comp_t b, input logic sub);
        logic signed [CW:0] s;
        s = sub ? ({a[CW-1], a} - {b[CW-1], b}) : ({a[CW-1], a} + {b[CW-1], b});
        if (s[CW] != s[CW-1])
            return s[CW] ? {1'b1, {(CW-1){1'b0}}} : {1'b0, {(CW-1){1'b1}}};
        return s[CW-1:0];
    endfunction

    function automatic cplx_t cx_sum(input cplx_t a, input cplx_t b, input logic sub);
        cplx_t r;
        r.re = sat_sum(a.re, b.re, sub);
        r.im = sat_sum(a.im, b.im, sub);
        return r;
    endfunction

    // atan(2^-i) in units of pi/2^(AW-1+ZX)
    function automatic logic signed [ZW-1:0] atan_step(input int i);
        case (i)
            0:  return ZW'(8192);
            1:  return ZW'(4836);
            2:  return ZW'(2555);
            3:  return ZW'(1297);
            4:  return ZW'(651);
            5:  return ZW'(326);
            6:  return ZW'(163);
            7:  return ZW'(81);
            8:  return ZW'(41);
            9:  return ZW'(20);
            10: return ZW'(10);
            11: return ZW'(5);
            12: return ZW'(3);
            13: return ZW'(1);
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/cbf_front.sv
module cbf_front
    import cbf_pkg::*;
(
    input  logic            pair_mode,
    input  cplx_t [3:0]     d_in,
    output cplx_t [3:0]     d_out
);

    cplx_t s02, d02, s13, d13;

    always_comb begin
        s02 = cx_sum(d_in[0], d_in[2], 1'b0);
        d02 = cx_sum(d_in[0], d_in[2], 1'b1);
        s13 = cx_sum(d_in[1], d_in[3], 1'b0);
        d13 = cx_sum(d_in[1], d_in[3], 1'b1);
        if (pair_mode) begin
            d_out[0] = cx_sum(d_in[0], d_in[1], 1'b0);
            d_out[1] = cx_sum(d_in[0], d_in[1], 1'b1);
            d_out[2] = cx_sum(d_in[2], d_in[3], 1'b0);
            d_out[3] = cx_sum(d_in[2], d_in[3], 1'b1);
        end else begin
            d_out[0] = cx_sum(s02, s13, 1'b0);
            d_out[1] = cx_sum(s02, s13, 1'b1);
            // -j*d folded in: swap parts, sign absorbed by add/sub choice
            d_out[2].re = sat_sum(d02.re, d13.im, 1'b0);
            d_out[2].im = sat_sum(d02.im, d13.re, 1'b1);
            d_out[3].re = sat_sum(d02.re, d13.im, 1'b1);
            d_out[3].im = sat_sum(d02.im, d13.re, 1'b0);
        end
    end

endmodule

// File: rtl/cbf_rotor.sv
module cbf_rotor
    import cbf_pkg::*;
#(
    parameter int ITERS = 12,
    parameter int GUARD = 3,
    parameter int KBITS = 12,
    parameter int KINV  = 2487          // round(2^KBITS / CORDIC gain)
)(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 go,
    input  cplx_t                v_in,
    input  logic signed [AW-1:0] ang,
    output logic                 fin,
    output cplx_t                v_out
);

    localparam int IW  = CW + GUARD + 3;
    localparam int PW  = IW + KBITS + 2;
    localparam int IC  = (ITERS > 1) ? $clog2(ITERS) : 1;
    localparam int QTR = 2 ** (AW - 2);
    localparam int SH  = KBITS + GUARD;
    localparam logic signed [PW-1:0] VMAX = PW'(2 ** (CW - 1) - 1);
    localparam logic signed [PW-1:0] VMIN = -VMAX - PW'(1);
    localparam logic signed [PW-1:0] RND  = PW'(2 ** (SH - 1));

    function automatic comp_t sat_w(input logic signed [PW-1:0] v);
        if (v > VMAX) return VMAX[CW-1:0];
        if (v < VMIN) return VMIN[CW-1:0];
        return v[CW-1:0];
    endfunction

    rot_state_t               st;
    logic signed [IW-1:0]     x, y, fx, fy, xs, ys;
    logic signed [ZW-1:0]     z;
    logic [IC-1:0]            it;
    logic                     flip;
    logic signed [AW-1:0]     resid;
    logic signed [PW-1:0]     px, py;

    always_comb begin
        flip  = (ang > QTR) || (ang < -QTR);
        resid = flip ? {~ang[AW-1], ang[AW-2:0]} : ang;
        fx    = IW'(v_in.re) <<< GUARD;
        fy    = IW'(v_in.im) <<< GUARD;
        if (flip) begin
            fx = -fx;
            fy = -fy;
        end
        xs = x >>> it;
        ys = y >>> it;
        px = (PW'(x) * PW'(KINV) + RND) >>> SH;
        py = (PW'(y) * PW'(KINV) + RND) >>> SH;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= R_IDLE;
            x     <= '0;
            y     <= '0;
            z     <= '0;
            it    <= '0;
            fin   <= 1'b0;
            v_out <= '0;
        end else begin
            fin <= 1'b0;
            case (st)
                R_IDLE: if (go) begin
                    if (resid == '0) begin
                        v_out.re <= sat_w(PW'(fx >>> GUARD));
                        v_out.im <= sat_w(PW'(fy >>> GUARD));
                        fin      <= 1'b1;
                    end else begin
                        x  <= fx;
                        y  <= fy;
                        z  <= ZW'(resid) <<< ZX;
                        it <= '0;
                        st <= R_ITER;
                    end
                end
                R_ITER: begin
                    if (!z[ZW-1]) begin
                        x <= x - ys;
                        y <= y + xs;
                        z <= z - atan_step(int'(it));
                    end else begin
                        x <= x + ys;
                        y <= y - xs;
                        z <= z + atan_step(int'(it));
                    end
                    if (it == IC'(ITERS - 1)) st <= R_COMP;
                    else                      it <= it + 1'b1;
                end
                default: begin
                    v_out.re <= sat_w(px);
                    v_out.im <= sat_w(py);
                    fin      <= 1'b1;
                    st       <= R_IDLE;
                end
            endcase
        end
    end

endmodule

// File: rtl/cbf_pe.sv
module cbf_pe
    import cbf_pkg::*;
#(
    parameter int ITERS = 12,
    parameter int GUARD = 3
)(
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic                pair_mode,
    input  logic [2*CW-1:0]     x0,
    input  logic [2*CW-1:0]     x1,
    input  logic [2*CW-1:0]     x2,
    input  logic [2*CW-1:0]     x3,
    input  logic [AW-1:0]       ang1,
    input  logic [AW-1:0]       ang2,
    input  logic [AW-1:0]       ang3,
    output logic                busy,
    output logic                done,
    output logic [2*CW-1:0]     y0,
    output logic [2*CW-1:0]     y1,
    output logic [2*CW-1:0]     y2,
    output logic [2*CW-1:0]     y3
);

    seq_state_t           st;
    cplx_t [3:0]          xin, fr, res;
    logic [3:0][AW-1:0]   angr;
    logic [1:0]           k;
    logic                 go_q, fin;
    cplx_t                rot_out;

    assign xin = {cplx_t'(x3), cplx_t'(x2), cplx_t'(x1), cplx_t'(x0)};

    cbf_front u_front (
        .pair_mode (pair_mode),
        .d_in      (xin),
        .d_out     (fr)
    );

    cbf_rotor #(.ITERS(ITERS), .GUARD(GUARD)) u_rot (
        .clk   (clk),
        .rst   (rst),
        .go    (go_q),
        .v_in  (res[k]),
        .ang   ($signed(angr[k])),
        .fin   (fin),
        .v_out (rot_out)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= S_IDLE;
            res  <= '0;
            angr <= '0;
            k    <= '0;
            go_q <= 1'b0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            go_q <= 1'b0;
            case (st)
                S_IDLE: if (start) begin
                    res  <= fr;
                    angr <= {ang3, ang2, ang1, {AW{1'b0}}};
                    k    <= 2'd1;
                    go_q <= 1'b1;
                    st   <= S_ROT;
                end
                default: if (fin) begin
                    res[k] <= rot_out;
                    if (k == 2'd3) begin
                        st   <= S_IDLE;
                        done <= 1'b1;
                    end else begin
                        k    <= k + 2'd1;
                        go_q <= 1'b1;
                    end
                end
            endcase
        end
    end

    assign busy = (st == S_ROT);
    assign y0   = res[0];
    assign y1   = res[1];
    assign y2   = res[2];
    assign y3   = res[3];

endmodule

// File: rtl/cbf_pe_chk.sv
module cbf_pe_chk
    import cbf_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            start,
    input logic            busy,
    input logic            done,
    input logic [2*CW-1:0] y0,
    input logic [2*CW-1:0] y1,
    input logic [2*CW-1:0] y2,
    input logic [2*CW-1:0] y3
);

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);

    // R7
    done_idle_chk: assert property (@(posedge clk) disable iff (rst) done |-> !busy);

    // R7
    start_accept_chk: assert property (@(posedge clk) disable iff (rst) (!busy && start) |=> busy);

    // R6
    done_after_busy_chk: assert property (@(posedge clk) disable iff (rst) done |-> $past(busy));

    // R4
    y0_unrotated_chk: assert property (@(posedge clk) disable iff (rst) busy |=> $stable(y0));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> ($stable(y0) && $stable(y1) && $stable(y2) && $stable(y3)));

endmodule

bind cbf_pe cbf_pe_chk u_chk (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
    .y0(y0), .y1(y1), .y2(y2), .y3(y3)
);

// File: tb/cbf_pe_test.sv
module cbf_pe_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        pair_mode = 1'b0;
    logic [23:0] x0 = '0, x1 = '0, x2 = '0, x3 = '0;
    logic [11:0] ang1 = '0, ang2 = '0, ang3 = '0;
    logic        busy, done;
    logic [23:0] y0, y1, y2, y3;

    cbf_pe uut (
        .clk(clk), .rst(rst), .start(start), .pair_mode(pair_mode),
        .x0(x0), .x1(x1), .x2(x2), .x3(x3),
        .ang1(ang1), .ang2(ang2), .ang3(ang3),
        .busy(busy), .done(done), .y0(y0), .y1(y1), .y2(y2), .y3(y3)
    );

    always #2 clk = ~clk;   // 250 MHz

    int checks = 0;
    int errors = 0;
    int xr[4], xi[4], er[4], ei[4], tol[4], ang[4];
    int pend_lat = 0;
    int m_cnt = 0;
    bit m_done = 0;
    bit run_cmp = 0;

    task automatic check(string req, int act, int exp, int tl);
        checks++;
        if (act > exp + tl || act < exp - tl) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int s12(int v);
        if (v > 2047) return 2047;
        if (v < -2048) return -2048;
        return v;
    endfunction

    function automatic logic [23:0] pk(int re, int im);
        logic [11:0] r, i;
        r = re[11:0];
        i = im[11:0];
        return {r, i};
    endfunction

    function automatic int gre(logic [23:0] v);
        return int'($signed(v[23:12]));
    endfunction

    function automatic int gim(logic [23:0] v);
        return int'($signed(v[11:0]));
    endfunction

    // reference: butterfly with saturation, then rotation; also latency
    task automatic calc(bit mode);
        int ar, ai, br, bi, cr, ci, dr, di, lat;
        real th, rr, ri;
        if (mode) begin
            er[0] = s12(xr[0] + xr[1]); ei[0] = s12(xi[0] + xi[1]);
            er[1] = s12(xr[0] - xr[1]); ei[1] = s12(xi[0] - xi[1]);
            er[2] = s12(xr[2] + xr[3]); ei[2] = s12(xi[2] + xi[3]);
            er[3] = s12(xr[2] - xr[3]); ei[3] = s12(xi[2] - xi[3]);
        end else begin
            ar = s12(xr[0] + xr[2]); ai = s12(xi[0] + xi[2]);
            br = s12(xr[0] - xr[2]); bi = s12(xi[0] - xi[2]);
            cr = s12(xr[1] + xr[3]); ci = s12(xi[1] + xi[3]);
            dr = s12(xr[1] - xr[3]); di = s12(xi[1] - xi[3]);
            er[0] = s12(ar + cr); ei[0] = s12(ai + ci);
            er[1] = s12(ar - cr); ei[1] = s12(ai - ci);
            er[2] = s12(br + di); ei[2] = s12(bi - dr);
            er[3] = s12(br - di); ei[3] = s12(bi + dr);
        end
        lat = 0;
        tol[0] = 0;
        for (int k = 1; k < 4; k++) begin
            if (ang[k] == 0) begin
                tol[k] = 0; lat += 2;
            end else if (ang[k] == -2048) begin
                er[k] = s12(-er[k]); ei[k] = s12(-ei[k]);
                tol[k] = 0; lat += 2;
            end else begin
                th = real'(ang[k]) * 3.14159265358979 / 2048.0;
                rr = real'(er[k]) * $cos(th) - real'(ei[k]) * $sin(th);
                ri = real'(er[k]) * $sin(th) + real'(ei[k]) * $cos(th);
                er[k] = s12($rtoi(rr + (rr >= 0.0 ? 0.5 : -0.5)));
                ei[k] = s12($rtoi(ri + (ri >= 0.0 ? 0.5 : -0.5)));
                tol[k] = 4; lat += 15;
            end
        end
        pend_lat = lat;
    endtask

    // cycle model of busy / done
    always @(posedge clk) begin
        if (rst) begin
            m_cnt  = 0;
            m_done = 0;
        end else begin
            m_done = (m_cnt == 1);
            if (m_cnt > 0) m_cnt = m_cnt - 1;
            else if (start) m_cnt = pend_lat;
        end
    end

    always @(negedge clk) begin
        if (run_cmp) begin
            check("R7 busy", int'(busy), int'(m_cnt > 0), 0);
            check("R6 done timing", int'(done), int'(m_done), 0);
        end
    end

    task automatic apply(bit mode);
        @(negedge clk);
        pair_mode = mode;
        x0 = pk(xr[0], xi[0]); x1 = pk(xr[1], xi[1]);
        x2 = pk(xr[2], xi[2]); x3 = pk(xr[3], xi[3]);
        ang1 = ang[1][11:0]; ang2 = ang[2][11:0]; ang3 = ang[3][11:0];
        calc(mode);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        int n = 0;
        while (!done && n < 200) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic check_out(string req);
        logic [23:0] ys[4];
        ys[0] = y0; ys[1] = y1; ys[2] = y2; ys[3] = y3;
        for (int k = 0; k < 4; k++) begin
            check({req, " re"}, gre(ys[k]), er[k], tol[k]);
            check({req, " im"}, gim(ys[k]), ei[k], tol[k]);
        end
    endtask

    task automatic run_op(bit mode, string req);
        apply(mode);
        wait_done();
        check_out(req);
        repeat (3) @(negedge clk);
        check_out("R9 hold after done");
    endtask

    task automatic set_x(int a0, int b0, int a1, int b1, int a2, int b2, int a3, int b3);
        xr[0] = a0; xi[0] = b0; xr[1] = a1; xi[1] = b1;
        xr[2] = a2; xi[2] = b2; xr[3] = a3; xi[3] = b3;
    endtask

    task automatic set_a(int a1, int a2, int a3);
        ang[0] = 0; ang[1] = a1; ang[2] = a2; ang[3] = a3;
    endtask

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R8: reset state
        check("R8 busy", int'(busy), 0, 0);
        check("R8 done", int'(done), 0, 0);
        check("R8 y0", int'(y0), 0, 0);
        check("R8 y3", int'(y3), 0, 0);
        run_cmp = 1;

        // R1: radix-2^2 with zero angles (bit exact)
        set_x(100, -50, 30, 20, -200, 75, 10, -400);
        set_a(0, 0, 0);
        run_op(1'b0, "R1 radix-2^2");

        // R2: same samples in pair mode
        run_op(1'b1, "R2 pair mode");

        // R3: saturation in both adder levels
        set_x(2000, -2000, 1500, -1500, 1000, -1000, -1500, 1500);
        run_op(1'b0, "R3 saturation");
        set_x(-2048, 2047, 100, -100, 2047, -2048, -5, 5);
        run_op(1'b1, "R3 saturation pair");

        // R4: general rotations, all quadrants
        set_x(300, -120, -250, 410, 90, 60, -330, -170);
        set_a(300, -700, 1500);
        run_op(1'b0, "R4 rotation");
        set_a(1024, -1024, -1500);
        run_op(1'b1, "R4 rotation quarter");

        // R5: pi and zero angles mixed with a general one
        set_x(-2048, 0, 0, 5, 700, -300, 200, 100);
        set_a(-2048, 0, 600);
        run_op(1'b1, "R5 pi/zero");

        // R7: start while busy is ignored
        set_x(123, 45, -67, 89, 210, -99, -15, 33);
        set_a(-300, 900, 2000);
        apply(1'b0);
        repeat (5) @(negedge clk);
        x0 = pk(1000, 1000);
        ang1 = 12'd5;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        check_out("R7 ignored start");

        // R1 R2 R4 R6: sweep of patterns and angles
        for (int j = 0; j < 10; j++) begin
            set_x((j * 137) % 900 - 450, 300 - (j * 71) % 600,
                  (j * 53) % 700 - 350, (j * 97) % 800 - 400,
                  400 - (j * 113) % 800, (j * 29) % 500 - 250,
                  (j * 61) % 600 - 300, 200 - (j * 83) % 400);
            set_a(((j * 411) % 4096) - 2048, (j % 3 == 0) ? 0 : ((j * 777) % 4096) - 2048,
                  (j % 4 == 1) ? -2048 : ((j * 1237) % 4096) - 2048);
            run_op(j[0], j[0] ? "R2 R4 sweep" : "R1 R4 sweep");
        end

        run_cmp = 0;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule